// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Matcher

This block watches a running clock and raises an alarm when the current minutes, hours and day-of-week agree with three programmed alarm registers. Each alarm register holds a BCD value in the same format as the matching time register, and bit 7 of each register is a don't-care mask for that field. Setting the masks in nesting order gives four alarm rates from one comparator. With the day masked, the alarm is daily. With the day and the hour masked, it is hourly. With all three masked, it fires every minute. With no masks set, it is weekly.

The time inputs carry the clock's already-incremented internal copy. The clock raises a tick on every hundredths update. The comparison is taken only on the tick where the hundredths count reads 99 and the incoming seconds value is 00, so the alarm lines up with the rollover into a new minute. A sticky flag records the match. An interrupt request is the flag gated by an external mask input. Any read or write of one of the three alarm registers clears the flag.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset the flag and the interrupt request are 0, and all three alarm registers read 0.
- R2: Register select 0 is the minutes alarm and select 1 is the hours alarm. Both store and read back all 8 bits as written. Bit 7 is the mask bit.
- R3: Register select 2 is the day alarm. It keeps bit 7 and bits 2:0, and bits 6:3 always read 0.
- R4: With no mask bit set, the flag sets only when minutes bits 6:0, hours bits 6:0 and day bits 2:0 all equal the alarm values.
- R5: With only the day mask set, the flag sets when minutes and hours match, whatever the day is.
- R6: With the day and hour masks set, the flag sets when minutes match, whatever the hour and day are.
- R7: With all three masks set, the flag sets at every evaluation, which is once per minute.
- R8: The comparison is evaluated only on a cycle where the tick is high, the hundredths input equals 0x99 and the seconds input equals 0x00. The flag is visible one clock later.
- R9: Once set, the flag holds until a register access. Evaluations that do not match do not clear it.
- R10: A read or write with select 0, 1 or 2 clears the flag in the next cycle. Select 3 addresses nothing, reads 0, and leaves the flag unchanged.
- R11: If an access and a qualifying match fall in the same cycle, the access wins and the flag ends up 0.
- R12: The interrupt request equals the flag while the interrupt mask input is 0, and is 0 while the mask is 1. The mask never changes the flag.
- R13: The hours comparison uses the raw byte, including the 12/24-hour bit 6 and the AM/PM bit 5. An alarm written in one format does not match a clock running in the other format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register select: 0 minutes, 1 hours, 2 day, 3 none |
| reg_rd_i | input | 1 | Read strobe, one cycle per access |
| reg_wr_i | input | 1 | Write strobe, one cycle per access |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register (combinational) |
| tick_i | input | 1 | Hundredths update strobe |
| cur_hsec_i | input | 8 | Hundredths count, BCD |
| cur_sec_i | input | 8 | Seconds, BCD |
| cur_min_i | input | 8 | Minutes, BCD |
| cur_hour_i | input | 8 | Hours byte, raw |
| cur_day_i | input | 8 | Day of week, BCD |
| int_mask_i | input | 1 | 1 gates off the interrupt request |
| flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A register access can land in the same cycle as a qualifying evaluation. In that cycle, the flag's clear and its set compete for one register. The bench provokes this by asserting a read strobe during the very tick that would set the flag, with every mask bit set. It then judges the flag one cycle later, where it must be 0. A second pass repeats the matching tick without the access to show that the same stimulus would otherwise have set the flag.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 3;
  localparam int SEL_W      = 2;
  localparam int MASK_BIT   = BYTE_W - 1;
  localparam int DAY_W      = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_MIN  = 2'd0,
    SEL_HOUR = 2'd1,
    SEL_DAY  = 2'd2,
    SEL_NONE = 2'd3
  } alarm_sel_e;

  // compared value bits per field, mask bit excluded
  function automatic int field_cmp_w(int idx);
    return (idx == int'(SEL_DAY)) ? DAY_W : MASK_BIT;
  endfunction

  // bits a field keeps on write
  function automatic logic [BYTE_W-1:0] field_keep(int idx);
    logic [BYTE_W-1:0] k;
    k = '0;
    k[MASK_BIT] = 1'b1;
    for (int b = 0; b < MASK_BIT; b++) k[b] = (b < field_cmp_w(idx));
    return k;
  endfunction
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [SEL_W-1:0]                    sel_i,
  input  logic                                rd_i,
  input  logic                                wr_i,
  input  logic [BYTE_W-1:0]                   wdata_i,
  output logic [BYTE_W-1:0]                   rdata_o,
  output logic                                access_o,
  output logic [NUM_FIELDS-1:0][BYTE_W-1:0]   alarm_o
);
  logic sel_ok;
  assign sel_ok   = (sel_i < SEL_W'(NUM_FIELDS));
  assign access_o = (rd_i | wr_i) & sel_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [BYTE_W-1:0] KEEP = field_keep(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               alarm_o[i] <= '0;
      else if (wr_i && sel_i == SEL_W'(i))       alarm_o[i] <= wdata_i & KEEP;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (sel_i == SEL_W'(i)) rdata_o = alarm_o[i];
  end

  assert_day_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_DAY) |-> (rdata_o[MASK_BIT-1:DAY_W] == '0));
endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
  import tod_alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alarm_i,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] now_i,
  output logic                              hit_o
);
  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    localparam int W = field_cmp_w(i);
    assign field_ok[i] = alarm_i[i][MASK_BIT] |
                         (alarm_i[i][W-1:0] == now_i[i][W-1:0]);
    if (W < MASK_BIT) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^{alarm_i[i][MASK_BIT-1:W], now_i[i][BYTE_W-1:W]};
    end else begin : g_full
      logic unused_top;
      assign unused_top = now_i[i][MASK_BIT];
    end
  end

  assign hit_o = &field_ok;
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eval_i,
  input  logic hit_i,
  input  logic clear_i,
  input  logic int_mask_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_o <= 1'b0;
    else if (clear_i)          flag_o <= 1'b0;   // access beats a same-cycle match
    else if (eval_i && hit_i)  flag_o <= 1'b1;
  end

  assign irq_o = flag_o & ~int_mask_i;

  assert_access_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !flag_o);
  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clear_i) |=> flag_o);
  assert_set_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(eval_i && hit_i && !clear_i));
  assert_race_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && eval_i && hit_i) |=> !flag_o);
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
#(
  parameter logic [7:0] HSEC_LAST = 8'h99,
  parameter logic [7:0] SEC_FIRST = 8'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  reg_sel_i,
  input  logic        reg_rd_i,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic        tick_i,
  input  logic [7:0]  cur_hsec_i,
  input  logic [7:0]  cur_sec_i,
  input  logic [7:0]  cur_min_i,
  input  logic [7:0]  cur_hour_i,
  input  logic [7:0]  cur_day_i,
  input  logic        int_mask_i,
  output logic        flag_o,
  output logic        irq_o
);
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alarm, now;
  logic access, hit, eval;

  assign now[SEL_MIN]  = cur_min_i;
  assign now[SEL_HOUR] = cur_hour_i;
  assign now[SEL_DAY]  = cur_day_i;
  assign eval = tick_i && (cur_hsec_i == HSEC_LAST) && (cur_sec_i == SEC_FIRST);

  tod_alarm_regs u_regs (
    .clk_i, .rst_ni,
    .sel_i   (reg_sel_i),
    .rd_i    (reg_rd_i),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .access_o(access),
    .alarm_o (alarm)
  );

  tod_alarm_cmp u_cmp (
    .alarm_i(alarm),
    .now_i  (now),
    .hit_o  (hit)
  );

  tod_alarm_flag u_flag (
    .clk_i, .rst_ni,
    .eval_i    (eval),
    .hit_i     (hit),
    .clear_i   (access),
    .int_mask_i,
    .flag_o,
    .irq_o
  );
endmodule

// File: tb/tod_alarm_match_test.sv
module tod_alarm_match_test;
  logic clk = 0, rst_ni = 0;
  logic [1:0] reg_sel = 0;
  logic reg_rd = 0, reg_wr = 0, tick = 0, int_mask = 0;
  logic [7:0] wdata = 0, rdata;
  logic [7:0] hsec = 0, sec = 0, mins = 0, hour = 0, day = 0;
  logic flag, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tod_alarm_match uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_sel_i(reg_sel), .reg_rd_i(reg_rd),
    .reg_wr_i(reg_wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tick_i(tick), .cur_hsec_i(hsec), .cur_sec_i(sec), .cur_min_i(mins),
    .cur_hour_i(hour), .cur_day_i(day), .int_mask_i(int_mask),
    .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk); reg_sel = s; wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1; #1 d = rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic set_alarm(logic [7:0] m, logic [7:0] h, logic [7:0] d);
    wr(0, m); wr(1, h); wr(2, d);
  endtask

  // one qualifying evaluation at time m/h/d; returns flag one clock later
  task automatic fire(logic [7:0] m, logic [7:0] h, logic [7:0] d, output logic f);
    @(negedge clk); mins = m; hour = h; day = d; hsec = 8'h99; sec = 8'h00; tick = 1;
    @(negedge clk); tick = 0; hsec = 8'h00; f = flag;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 flag", {7'd0, flag}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    for (int i = 0; i < 3; i++) begin rd(i[1:0], d); chk("R1 reg", d, 8'h00); end
  endtask

  task automatic t_rw;
    logic [7:0] d;
    wr(0, 8'hC5); rd(0, d); chk("R2 minutes", d, 8'hC5);
    wr(1, 8'h92); rd(1, d); chk("R2 hours", d, 8'h92);
    wr(2, 8'hFF); rd(2, d); chk("R3 day", d, 8'h87);
    rd(3, d); chk("R10 sel3 reads 0", d, 8'h00);
  endtask

  task automatic t_weekly;
    logic f; logic [7:0] d;
    set_alarm(8'h30, 8'h12, 8'h03);
    fire(8'h30, 8'h12, 8'h04, f); chk("R4 day differs", {7'd0, f}, 0);
    fire(8'h30, 8'h11, 8'h03, f); chk("R4 hour differs", {7'd0, f}, 0);
    fire(8'h31, 8'h12, 8'h03, f); chk("R4 min differs", {7'd0, f}, 0);
    fire(8'h30, 8'h12, 8'h03, f); chk("R4 full match", {7'd0, f}, 1);
    chk("R12 irq follows flag", {7'd0, irq}, 1);
    rd(0, d); chk("R10 read clears", {7'd0, flag}, 0);
  endtask

  task automatic t_daily;
    logic f;
    set_alarm(8'h30, 8'h12, 8'h81);
    fire(8'h30, 8'h12, 8'h06, f); chk("R5 daily match", {7'd0, f}, 1);
    wr(2, 8'h81);
    fire(8'h31, 8'h12, 8'h06, f); chk("R5 minute miss", {7'd0, f}, 0);
  endtask

  task automatic t_hourly;
    logic f;
    set_alarm(8'h30, 8'h85, 8'h81);
    fire(8'h30, 8'h07, 8'h02, f); chk("R6 hourly match", {7'd0, f}, 1);
    wr(1, 8'h85);
    fire(8'h29, 8'h05, 8'h01, f); chk("R6 minute miss", {7'd0, f}, 0);
  endtask

  task automatic t_minute_timing;
    logic f;
    set_alarm(8'h80, 8'h80, 8'h80);
    @(negedge clk); hsec = 8'h98; sec = 8'h00; tick = 1;
    @(negedge clk); tick = 0; chk("R8 hsec 98", {7'd0, flag}, 0);
    hsec = 8'h99; sec = 8'h59; tick = 1;
    @(negedge clk); tick = 0; chk("R8 sec 59", {7'd0, flag}, 0);
    hsec = 8'h99; sec = 8'h00;
    @(negedge clk); chk("R8 no tick", {7'd0, flag}, 0);
    fire(8'h17, 8'h03, 8'h05, f); chk("R7 per minute", {7'd0, f}, 1);
  endtask

  task automatic t_sticky_gate;
    logic f;
    wr(0, 8'h45); wr(1, 8'h80); wr(2, 8'h80);
    fire(8'h45, 8'h01, 8'h01, f); chk("R9 set", {7'd0, f}, 1);
    fire(8'h46, 8'h01, 8'h01, f); chk("R9 holds over miss", {7'd0, f}, 1);
    repeat (5) @(negedge clk);
    chk("R9 holds idle", {7'd0, flag}, 1);
    int_mask = 1; #1;
    chk("R12 masked irq", {7'd0, irq}, 0);
    @(negedge clk); chk("R12 flag unchanged", {7'd0, flag}, 1);
    int_mask = 0; #1;
    chk("R12 irq restored", {7'd0, irq}, 1);
    @(negedge clk); reg_sel = 3; reg_rd = 1;
    @(negedge clk); reg_rd = 0; chk("R10 sel3 keeps flag", {7'd0, flag}, 1);
    wr(2, 8'h80); chk("R10 write clears", {7'd0, flag}, 0);
  endtask

  task automatic t_race;
    logic f;
    set_alarm(8'h80, 8'h80, 8'h80);
    @(negedge clk); hsec = 8'h99; sec = 8'h00; tick = 1; reg_sel = 0; reg_rd = 1;
    @(negedge clk); tick = 0; reg_rd = 0; hsec = 8'h00;
    chk("R11 access wins", {7'd0, flag}, 0);
    fire(8'h00, 8'h00, 8'h00, f); chk("R11 same tick alone sets", {7'd0, f}, 1);
  endtask

  task automatic t_hour_mode;
    logic f;
    set_alarm(8'h10, 8'h52, 8'h80);
    fire(8'h10, 8'h12, 8'h01, f); chk("R13 24h clock no match", {7'd0, f}, 0);
    fire(8'h10, 8'h72, 8'h01, f); chk("R13 PM differs", {7'd0, f}, 0);
    fire(8'h10, 8'h52, 8'h01, f); chk("R13 12h match", {7'd0, f}, 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset;
    t_rw;
    t_weekly;
    t_daily;
    t_hourly;
    t_minute_timing;
    t_sticky_gate;
    t_race;
    t_hour_mode;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule